// File: doc/BRIEF.md
# Receive Packet Queue with Byte-Wide CPU Port

This block sits between a serial-bus link layer's receive path and a small 8-bit host processor. The link layer presents asynchronous packets one 32-bit quadlet per cycle, with start and end markers. The block keeps a packet only if two conditions hold: the destination identifier in the top half of the first quadlet equals the local node identifier, and the queue has room for every quadlet of the packet. A packet that fails either test leaves no trace in the queue. A packet becomes visible to the host only after its last quadlet has been stored. At that point a receive-done interrupt flag is raised.

The host reaches the block over a byte-wide strobe bus: an active-low select, active-low read and write strobes, and a 7-bit byte address. The strobes are brought into the clock domain through a synchronizer. Every register is 32 bits wide and is read as four byte addresses. A read of byte offset 0 latches the whole word, and offsets 1 to 3 then return the rest of that latched word. Byte offset 0 carries bits 31:24. Reading offset 0 of the queue port pops one quadlet. Reading the port when the queue is empty pops nothing and returns the quadlet that was popped last. An active-low interrupt line follows the receive-done flag gated by its mask bit.

Top module: `rxq_cpu_port`

## Requirements
- R1: After reset, irq_n is 1 and cpu_rdata is 00h. The status register (byte 1Ch) reads 80h and the interrupt register (byte 0Ch) reads 00h.
- R2: A packet is stored only if bits 31:16 of its first quadlet (the quadlet marked by rx_sop) equal local_id. A packet with a different identifier changes neither the queue contents nor the interrupt flag.
- R3: A packet that would not fit in the free space of the queue is discarded whole, and packets stored earlier stay intact. A packet that exactly fills the remaining space is stored.
- R4: Once an accepted packet's last quadlet (rx_eop) is stored, bit 25 of the interrupt register is set. Bit 31 of that register is set while any flag is pending, so byte 0Ch reads 82h when only receive-done is pending.
- R5: irq_n is driven low while the receive-done flag is set and bit 25 of the mask register (byte 10h, bit 1) is 1. Otherwise irq_n is high.
- R6: A host write to byte 0Ch with bit 1 set clears the receive-done flag, after which irq_n returns high. A write with bit 1 clear has no effect on the flag.
- R7: Bit 31 of the status register (byte 1Ch reads 80h) is 1 exactly when the queue holds no committed quadlet. It reads 00h while packet data remains.
- R8: A read of byte 74h pops the oldest quadlet and returns its bits 31:24. Reads of 75h, 76h and 77h then return bits 23:16, 15:8 and 7:0 of that same quadlet without popping. Quadlets come out in arrival order.
- R9: A read of byte 74h while the queue is empty pops nothing, and bytes 74h to 77h return the last quadlet popped. A packet that arrives afterwards is read back intact.
- R10: A read of any byte address outside 0Ch to 13h, 1Ch to 1Fh and 74h to 77h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive quadlet valid this cycle |
| rx_sop | input | 1 | Quadlet is the first of a packet |
| rx_eop | input | 1 | Quadlet is the last of a packet |
| rx_data | input | 32 | Receive quadlet; bits 31:16 of the first carry the destination identifier |
| local_id | input | 16 | Identifier of this node |
| cpu_cs_n | input | 1 | Host select, active low |
| cpu_rd_n | input | 1 | Host read strobe, active low |
| cpu_wr_n | input | 1 | Host write strobe, active low |
| cpu_addr | input | 7 | Host byte address |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Host read byte, registered |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
The bench builds the block with an 8-quadlet queue (DEPTH_LOG2 = 3) and two synchronizer stages. With this small queue, a five-quadlet packet followed by a four-quadlet packet overflows it, which reaches the whole-packet discard path. A three-quadlet packet after that exactly fills the remaining space, which reaches the full boundary and the pointer wrap. With two synchronizer stages each host access completes within a few clocks, so long sequences of byte reads fit the run.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Host bus byte address width and word index width
  localparam int CPU_AW = 7;
  localparam int IDX_W  = CPU_AW - 2;

  // Word indices (byte address divided by four)
  localparam logic [IDX_W-1:0] IDX_INT  = 5'h03;  // 0Ch
  localparam logic [IDX_W-1:0] IDX_MASK = 5'h04;  // 10h
  localparam logic [IDX_W-1:0] IDX_STAT = 5'h07;  // 1Ch
  localparam logic [IDX_W-1:0] IDX_PORT = 5'h1D;  // 74h

  // Bit positions inside 32-bit words; byte offset 0 holds bits 31:24
  localparam int SUM_BIT     = 31;
  localparam int RXDONE_BIT  = 25;
  localparam int EMPTY_BIT   = 31;
  localparam int RXDONE_LANE = RXDONE_BIT - 24;

  typedef enum logic {
    ADM_IDLE = 1'b0,
    ADM_TAKE = 1'b1
  } adm_state_e;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int IDW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic          rx_eop,
  input  logic [DW-1:0] rx_data,
  input  logic [IDW-1:0] local_id,
  input  logic [AW:0]   rd_ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic [AW:0]   vis_ptr,
  output logic          commit
);
  localparam int          PW    = AW + 1;
  localparam int          DEPTH = 1 << AW;
  localparam logic [PW-1:0] P_ONE = PW'(1);
  localparam logic [PW-1:0] CAP   = PW'(DEPTH);

  adm_state_e    st;
  logic [PW-1:0] base_ptr;   // end of last committed packet
  logic [PW-1:0] spec_ptr;   // next speculative write slot
  logic          eop_q;
  logic          id_hit, base_room, spec_room, start_ok, cont_ok;

  always_comb begin
    id_hit    = (rx_data[DW-1 -: IDW] == local_id);
    base_room = ((base_ptr - rd_ptr) != CAP);
    spec_room = ((spec_ptr - rd_ptr) != CAP);
    start_ok  = rx_valid && rx_sop && id_hit && base_room;
    cont_ok   = rx_valid && !rx_sop && (st == ADM_TAKE) && spec_room;
    we        = start_ok || cont_ok;
    waddr     = start_ok ? base_ptr[AW-1:0] : spec_ptr[AW-1:0];
    wdata     = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ADM_IDLE;
      base_ptr <= '0;
      spec_ptr <= '0;
      vis_ptr  <= '0;
      eop_q    <= 1'b0;
    end else begin
      eop_q   <= 1'b0;
      // Committed end becomes readable one cycle after the last write,
      // so the registered RAM read has caught up.
      vis_ptr <= base_ptr;
      if (rx_valid) begin
        if (rx_sop) begin
          // A new start abandons any unfinished packet
          if (start_ok) begin
            spec_ptr <= base_ptr + P_ONE;
            if (rx_eop) begin
              base_ptr <= base_ptr + P_ONE;
              eop_q    <= 1'b1;
              st       <= ADM_IDLE;
            end else begin
              st <= ADM_TAKE;
            end
          end else begin
            spec_ptr <= base_ptr;
            st       <= ADM_IDLE;
          end
        end else if (st == ADM_TAKE) begin
          if (spec_room) begin
            spec_ptr <= spec_ptr + P_ONE;
            if (rx_eop) begin
              base_ptr <= spec_ptr + P_ONE;
              eop_q    <= 1'b1;
              st       <= ADM_IDLE;
            end
          end else begin
            // Out of space: roll back to the last committed packet
            spec_ptr <= base_ptr;
            st       <= ADM_IDLE;
          end
        end
      end
    end
  end

  assign commit = eop_q;
endmodule

// File: rtl/rxq_cpu_bus.sv
module rxq_cpu_bus
  import rxq_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [CPU_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              fifo_empty,
  input  logic [31:0]       head_q,
  input  logic              commit,
  output logic [AW:0]       rd_ptr,
  output logic [7:0]        rdata,
  output logic              rx_flag,
  output logic              mask_bit
);
  localparam int            PW    = AW + 1;
  localparam logic [PW-1:0] P_ONE = PW'(1);
  localparam int            LANES = 4;

  logic             cs_s, rd_s, wr_s;
  logic             rd_act, wr_act, rd_act_q, wr_act_q, rd_evt, wr_evt;
  logic [IDX_W-1:0] idx;
  logic [1:0]       bsel;
  logic [7:0]       mask_b [LANES];
  logic [31:0]      mask_word, int_word, stat_word, port_word, sel_word;
  logic [31:0]      last_q;
  logic [23:0]      hold;

  rxq_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rd_n, wr_n}),
    .q   ({cs_s, rd_s, wr_s})
  );

  always_comb begin
    rd_act = !cs_s && !rd_s;
    wr_act = !cs_s && !wr_s;
    rd_evt = rd_act && !rd_act_q;
    wr_evt = wr_act && !wr_act_q;
    idx    = addr[CPU_AW-1:2];
    bsel   = addr[1:0];

    mask_word = {mask_b[0], mask_b[1], mask_b[2], mask_b[3]};
    int_word             = '0;
    int_word[SUM_BIT]    = rx_flag;
    int_word[RXDONE_BIT] = rx_flag;
    stat_word            = '0;
    stat_word[EMPTY_BIT] = fifo_empty;
    port_word = fifo_empty ? last_q : head_q;

    unique case (idx)
      IDX_INT:  sel_word = int_word;
      IDX_MASK: sel_word = mask_word;
      IDX_STAT: sel_word = stat_word;
      IDX_PORT: sel_word = port_word;
      default:  sel_word = '0;
    endcase
  end

  // Mask register: one writable byte lane per generate iteration
  for (genvar g = 0; g < LANES; g++) begin : g_mask_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_b[g] <= '0;
      end else if (wr_evt && idx == IDX_MASK && bsel == 2'(g)) begin
        mask_b[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      rd_ptr   <= '0;
      rdata    <= '0;
      hold     <= '0;
      last_q   <= '0;
      rx_flag  <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;

      if (rd_evt) begin
        if (bsel == 2'd0) begin
          rdata <= sel_word[31:24];
          hold  <= sel_word[23:0];
          if (idx == IDX_PORT && !fifo_empty) begin
            last_q <= head_q;
            rd_ptr <= rd_ptr + P_ONE;
          end
        end else begin
          unique case (bsel)
            2'd1:    rdata <= hold[23:16];
            2'd2:    rdata <= hold[15:8];
            default: rdata <= hold[7:0];
          endcase
        end
      end

      if (commit) begin
        rx_flag <= 1'b1;
      end else if (wr_evt && idx == IDX_INT && bsel == 2'd0 && wdata[RXDONE_LANE]) begin
        rx_flag <= 1'b0;
      end
    end
  end

  assign mask_bit = mask_b[0][RXDONE_LANE];
endmodule

// File: rtl/rxq_cpu_port.sv
module rxq_cpu_port
  import rxq_pkg::*;
#(
  parameter int DEPTH_LOG2  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [31:0]       rx_data,
  input  logic [15:0]       local_id,
  input  logic              cpu_cs_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq_n
);
  localparam int AW = DEPTH_LOG2;

  logic          we;
  logic [AW-1:0] waddr;
  logic [31:0]   wdata;
  logic [31:0]   head_q;
  logic [AW:0]   vis_ptr, rd_ptr;
  logic          commit, fifo_empty, rx_flag, mask_bit;

  rxq_admit #(.AW(AW), .DW(32), .IDW(16)) admit_i (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_sop   (rx_sop),
    .rx_eop   (rx_eop),
    .rx_data  (rx_data),
    .local_id (local_id),
    .rd_ptr   (rd_ptr),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .vis_ptr  (vis_ptr),
    .commit   (commit)
  );

  rxq_store #(.AW(AW), .DW(32)) store_i (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (head_q)
  );

  assign fifo_empty = (vis_ptr == rd_ptr);

  rxq_cpu_bus #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) bus_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cpu_cs_n),
    .rd_n       (cpu_rd_n),
    .wr_n       (cpu_wr_n),
    .addr       (cpu_addr),
    .wdata      (cpu_wdata),
    .fifo_empty (fifo_empty),
    .head_q     (head_q),
    .commit     (commit),
    .rd_ptr     (rd_ptr),
    .rdata      (cpu_rdata),
    .rx_flag    (rx_flag),
    .mask_bit   (mask_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(rx_flag && mask_bit);
  end
endmodule

// File: rtl/rxq_cpu_port_chk.sv
module rxq_cpu_port_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_n,
  input logic          rx_flag,
  input logic          mask_bit,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [AW:0]   rd_ptr,
  input logic [AW:0]   vis_ptr,
  input logic          fifo_empty,
  input logic          rx_valid,
  input logic          rx_sop,
  input logic [15:0]   rx_dest,
  input logic [15:0]   local_id
);
  AST_RESET_IRQ_HIGH: assert property (@(posedge clk) rst |=> irq_n); // R1

  AST_FOREIGN_ID_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sop && rx_dest != local_id) |-> !we); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (we && !fifo_empty) |-> (waddr != rd_ptr[AW-1:0])); // R3

  AST_FLAG_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (vis_ptr != $past(vis_ptr)) |-> rx_flag); // R4

  AST_IRQ_NEEDS_MASKED_FLAG: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(rx_flag && mask_bit)); // R5

  AST_POP_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr != $past(rd_ptr)) |-> $past(!fifo_empty)); // R9
endmodule

bind rxq_cpu_port rxq_cpu_port_chk #(.AW(DEPTH_LOG2)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_n      (irq_n),
  .rx_flag    (rx_flag),
  .mask_bit   (mask_bit),
  .we         (we),
  .waddr      (waddr),
  .rd_ptr     (rd_ptr),
  .vis_ptr    (vis_ptr),
  .fifo_empty (fifo_empty),
  .rx_valid   (rx_valid),
  .rx_sop     (rx_sop),
  .rx_dest    (rx_data[31:16]),
  .local_id   (local_id)
);

// File: tb/rxq_cpu_port_tb_top.sv
module rxq_cpu_port_tb_top;
  localparam int          CLK_P    = 10;
  localparam int          DLOG2    = 3;
  localparam logic [15:0] MY_ID    = 16'hFFC2;
  localparam int          NVEC     = 4;
  localparam int          WD_LIMIT = 150000;

  // Vector: {dest_id[15:0], length[7:0], seed[31:0], accept[7:0]}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'hFFC2, 8'd1, 32'h1234_5678, 8'd1},
    {16'hFFC3, 8'd2, 32'hDEAD_0001, 8'd0},
    {16'hFFC2, 8'd3, 32'hA5C3_0F0F, 8'd1},
    {16'h0000, 8'd1, 32'h0BAD_F00D, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [31:0] rx_data = '0;
  logic        cpu_cs_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [6:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rxq_cpu_port #(.DEPTH_LOG2(DLOG2), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst (rst),
    .rx_valid (rx_valid), .rx_sop (rx_sop), .rx_eop (rx_eop),
    .rx_data (rx_data), .local_id (MY_ID),
    .cpu_cs_n (cpu_cs_n), .cpu_rd_n (cpu_rd_n), .cpu_wr_n (cpu_wr_n),
    .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata), .irq_n (irq_n)
  );

  function automatic logic [31:0] qword(input logic [15:0] id, input logic [31:0] seed, input int k);
    if (k == 0) return {id, seed[15:0]};
    return seed ^ (32'(k) * 32'h0101_0101);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cpu_rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_cs_n = 1'b0; cpu_rd_n = 1'b0;
    repeat (6) @(negedge clk);
    d = cpu_rdata;
    cpu_cs_n = 1'b1; cpu_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_cs_n = 1'b0; cpu_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    cpu_cs_n = 1'b1; cpu_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_quad(output logic [31:0] q);
    logic [7:0] b0, b1, b2, b3;
    cpu_rd(7'h74, b0);
    cpu_rd(7'h75, b1);
    cpu_rd(7'h76, b2);
    cpu_rd(7'h77, b3);
    q = {b0, b1, b2, b3};
  endtask

  task automatic send_pkt(input logic [15:0] id, input int len, input logic [31:0] seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sop   = (k == 0);
      rx_eop   = (k == len - 1);
      rx_data  = qword(id, seed, k);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  b;
    logic [31:0] q;
    logic [31:0] last;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(irq_n == 1'b1, "R1 irq_n after reset", 32'(irq_n), 32'd1);
    check(cpu_rdata == 8'h00, "R1 rdata after reset", 32'(cpu_rdata), 32'h00);
    cpu_rd(7'h1C, b);
    check(b == 8'h80, "R1 R7 status empty after reset", 32'(b), 32'h80);
    cpu_rd(7'h0C, b);
    check(b == 8'h00, "R1 interrupt reg after reset", 32'(b), 32'h00);

    // Vector table: admission by identifier, drain in order (R2 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] id;
      int          len;
      logic [31:0] seed;
      bit          acc;
      id   = VEC[v][63:48];
      len  = int'(VEC[v][47:40]);
      seed = VEC[v][39:8];
      acc  = VEC[v][0];
      send_pkt(id, len, seed);
      cpu_rd(7'h1C, b);
      check(b == (acc ? 8'h00 : 8'h80), "R2 R7 status after packet", 32'(b), acc ? 32'h00 : 32'h80);
      if (acc) begin
        for (int k = 0; k < len; k++) begin
          read_quad(q);
          check(q == qword(id, seed, k), "R8 quadlet order and bytes", q, qword(id, seed, k));
        end
        cpu_rd(7'h1C, b);
        check(b == 8'h80, "R7 empty after drain", 32'(b), 32'h80);
      end
    end

    // R4: receive-done flag and summary bit
    cpu_rd(7'h0C, b);
    check(b == 8'h82, "R4 interrupt reg with receive-done", 32'(b), 32'h82);
    // R5: masked off -> line high
    check(irq_n == 1'b1, "R5 irq_n with mask clear", 32'(irq_n), 32'd1);
    cpu_wr(7'h10, 8'h02);
    check(irq_n == 1'b0, "R5 irq_n with mask set", 32'(irq_n), 32'd0);

    // R6: write of 0 does nothing, write of 1 clears
    cpu_wr(7'h0C, 8'h00);
    check(irq_n == 1'b0, "R6 zero write keeps irq", 32'(irq_n), 32'd0);
    cpu_rd(7'h0C, b);
    check(b == 8'h82, "R6 zero write keeps flag", 32'(b), 32'h82);
    cpu_wr(7'h0C, 8'h02);
    check(irq_n == 1'b1, "R6 clear releases irq", 32'(irq_n), 32'd1);
    cpu_rd(7'h0C, b);
    check(b == 8'h00, "R6 flag cleared", 32'(b), 32'h00);

    // R2: foreign packet sets no flag
    send_pkt(16'h1234, 2, 32'h5555_AAAA);
    cpu_rd(7'h0C, b);
    check(b == 8'h00, "R2 foreign packet no flag", 32'(b), 32'h00);
    check(irq_n == 1'b1, "R2 foreign packet no irq", 32'(irq_n), 32'd1);

    // R10: unmapped address
    cpu_rd(7'h1C, b);
    cpu_rd(7'h40, b);
    check(b == 8'h00, "R10 unmapped address", 32'(b), 32'h00);

    // R3: 5 fits, 4 does not fit (dropped), 3 exactly fills the 8 slots
    send_pkt(MY_ID, 5, 32'h1111_0000);
    send_pkt(MY_ID, 4, 32'h2222_0000);
    send_pkt(MY_ID, 3, 32'h3333_0000);
    cpu_rd(7'h0C, b);
    check(b == 8'h82, "R4 flag after fill", 32'(b), 32'h82);
    last = '0;
    for (int k = 0; k < 5; k++) begin
      read_quad(q);
      check(q == qword(MY_ID, 32'h1111_0000, k), "R3 first packet intact", q, qword(MY_ID, 32'h1111_0000, k));
    end
    for (int k = 0; k < 3; k++) begin
      read_quad(q);
      last = qword(MY_ID, 32'h3333_0000, k);
      check(q == last, "R3 filling packet stored", q, last);
    end
    cpu_rd(7'h1C, b);
    check(b == 8'h80, "R3 no trace of dropped packet", 32'(b), 32'h80);

    // R9: empty read repeats last quadlet without popping
    read_quad(q);
    check(q == last, "R9 empty read repeats last", q, last);
    cpu_rd(7'h1C, b);
    check(b == 8'h80, "R9 still empty", 32'(b), 32'h80);
    send_pkt(MY_ID, 1, 32'h4444_BEEF);
    read_quad(q);
    check(q == qword(MY_ID, 32'h4444_BEEF, 0), "R9 next packet intact", q, qword(MY_ID, 32'h4444_BEEF, 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule